// File: doc/BRIEF.md
# Correlated Double-Sample Row Readout Sequencer

This block drives a pixel matrix that is read one row at a time. For each row it turns on that row's gate-select line and lets the row settle. It then strobes the column digitizers to capture a sample that holds signal plus pedestal. Next it pulses the row's reset (clear) line and strobes the digitizers again, this time capturing the pedestal alone. Finally it streams the per-column difference of the two captures, one column per cycle. It then steps to the next row, and after the last row it wraps back to row 0.

All column samples arrive together on one wide bus. The block latches that bus only on the cycles in which it raises a capture strobe. Both captures are held in per-column register banks. The subtraction is done as the words are streamed out, so the word for column k is ready in cycle k of the output phase.

A single run input starts and stops the scan. When run is dropped in the middle of a row, the block finishes that row, including its output stream. It then parks with every gate and clear line low. The next start always begins at row 0.

Top module: `cds_row_sequencer`

## Requirements
- R1: At most one bit of `gate_row` is high in any cycle.
- R2: Each row follows this order, where S = `SETTLE_CYC` and C = `CLEAR_CYC`. The row's gate is high for S cycles with no strobe. `sig_strobe` is then high for one cycle with the gate still high. The row's clear line is then high for C cycles. `ped_strobe` is then high for one cycle with the clear line low. The gate then drops, and streaming follows in the next cycle.
- R3: A bit of `clear_row` is only ever high while the same bit of `gate_row` is high.
- R4: `col_samples` (column k at bits k*SAMPLE_W upward) is latched only on the clock edge that ends a cycle with the matching strobe high. Values on the bus at any other time have no effect on the output.
- R5: `out_diff` is the first capture minus the second capture, both unsigned, as a signed (SAMPLE_W+1)-bit two's-complement value. The full range from -(2^SAMPLE_W-1) to +(2^SAMPLE_W-1) comes out without wrapping.
- R6: After `ped_strobe`, `out_valid` is high for exactly NUM_COLS consecutive cycles. `out_col` runs 0, 1, …, NUM_COLS-1 over those cycles, and `out_row` gives the row just sampled.
- R7: While run stays high, the row index increases by one per row period of S+C+2+NUM_COLS cycles. After NUM_ROWS-1 it returns to 0.
- R8: `out_eof` is high only on the word for row NUM_ROWS-1 and column NUM_COLS-1.
- R9: When idle, the first cycle in which run is seen high starts row 0 on the next cycle. If run is low at the last streaming cycle of a row, the block goes idle. In idle every gate and clear line is low, and the next start is from row 0.
- R10: While reset is high and after it is released, all gate, clear, strobe and valid outputs are low until run is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Scan enable; sampled at row boundaries and in idle |
| col_samples | input | NUM_COLS*SAMPLE_W | Digitized column values, column k at bits [k*SAMPLE_W +: SAMPLE_W] |
| gate_row | output | NUM_ROWS | One-hot row gate-select lines |
| clear_row | output | NUM_ROWS | One-hot row clear lines |
| sig_strobe | output | 1 | Capture strobe for signal-plus-pedestal sample |
| ped_strobe | output | 1 | Capture strobe for pedestal-only sample |
| out_valid | output | 1 | Difference word valid |
| out_row | output | ROW_W | Row index of the current word |
| out_col | output | COL_W | Column index of the current word |
| out_diff | output | SAMPLE_W+1 | Signed difference, first capture minus second |
| out_eof | output | 1 | Last word of the frame |

## Verification
A phase or counter error in the sequencer shows up at once as a gate, clear or strobe edge in the wrong cycle of the row period. A row counter error shows up in the first gate pattern of the next row. A capture taken on the wrong edge, or a bank addressed by the wrong column, puts a wrong `out_diff` on the first word it affects. Because non-strobe cycles drive a fixed filler on the bus, such an error is very unlikely to match by chance. A wrong wrap or stop decision shows within one row period, as a wrong `out_row`, a missing idle, or a misplaced `out_eof`.

// File: rtl/cds_rowseq_pkg.sv
package cds_rowseq_pkg;

    // Step of the per-row sequence
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_SIG,
        PH_CLEAR,
        PH_PED,
        PH_STREAM
    } phase_e;

    localparam int DEFAULT_SAMPLE_W = 16;

    // Counter width able to hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // Row gate is on from settle through the second capture
    function automatic logic phase_drives_gate(input phase_e ph);
        return (ph == PH_SETTLE) || (ph == PH_SIG) ||
               (ph == PH_CLEAR)  || (ph == PH_PED);
    endfunction

endpackage

// File: rtl/cds_row_timer.sv
module cds_row_timer
    import cds_rowseq_pkg::*;
#(
    parameter int NUM_ROWS   = 64,
    parameter int NUM_COLS   = 128,
    parameter int SETTLE_CYC = 2,
    parameter int CLEAR_CYC  = 2,
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    output phase_e              phase,
    output logic [ROW_W-1:0]    row_idx,
    output logic [COL_W-1:0]    col_idx,
    output logic [NUM_ROWS-1:0] gate_row,
    output logic [NUM_ROWS-1:0] clear_row,
    output logic                sig_stb,
    output logic                ped_stb
);
    localparam int MAX_SPAN = (NUM_COLS > SETTLE_CYC) ?
                              ((NUM_COLS > CLEAR_CYC) ? NUM_COLS : CLEAR_CYC) :
                              ((SETTLE_CYC > CLEAR_CYC) ? SETTLE_CYC : CLEAR_CYC);
    localparam int CNT_W = cnt_width(MAX_SPAN);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CLEAR_END  = CNT_W'(CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] STREAM_END = CNT_W'(NUM_COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW   = ROW_W'(NUM_ROWS - 1);

    phase_e           phase_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            row_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    row_q <= '0;
                    if (run) phase_q <= PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (cnt_q == SETTLE_END) begin
                        phase_q <= PH_SIG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SIG: begin
                    phase_q <= PH_CLEAR;
                    cnt_q   <= '0;
                end
                PH_CLEAR: begin
                    if (cnt_q == CLEAR_END) begin
                        phase_q <= PH_PED;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PED: begin
                    phase_q <= PH_STREAM;
                    cnt_q   <= '0;
                end
                PH_STREAM: begin
                    if (cnt_q == STREAM_END) begin
                        cnt_q <= '0;
                        if (run) begin
                            phase_q <= PH_SETTLE;
                            row_q   <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
                        end else begin
                            phase_q <= PH_IDLE;
                            row_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    logic gate_on, clear_on;
    assign gate_on  = phase_drives_gate(phase_q);
    assign clear_on = (phase_q == PH_CLEAR);

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row_lines
        assign gate_row[g]  = gate_on  && (row_q == ROW_W'(g));
        assign clear_row[g] = clear_on && (row_q == ROW_W'(g));
    end

    assign phase   = phase_q;
    assign row_idx = row_q;
    assign col_idx = cnt_q[COL_W-1:0];
    assign sig_stb = (phase_q == PH_SIG);
    assign ped_stb = (phase_q == PH_PED);

    // R1
    always_comb gate_onehot_chk: assert (rst || $onehot0(gate_row));

    // R3
    clear_in_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|clear_row) |-> (clear_row == gate_row));

    // R2
    sig_then_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sig_stb |=> ((|clear_row) && $stable(gate_row)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> (gate_row == '0 && clear_row == '0));

endmodule

// File: rtl/cds_sample_bank.sv
module cds_sample_bank #(
    parameter int NUM_COLS = 128,
    parameter int SAMPLE_W = 16,
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap_sig,
    input  logic                         cap_ped,
    input  logic [NUM_COLS*SAMPLE_W-1:0] col_samples,
    input  logic [COL_W-1:0]             col_sel,
    output logic [SAMPLE_W-1:0]          sig_word,
    output logic [SAMPLE_W-1:0]          ped_word
);
    logic [SAMPLE_W-1:0] sig_q [NUM_COLS];
    logic [SAMPLE_W-1:0] ped_q [NUM_COLS];

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst) begin
                sig_q[c] <= '0;
                ped_q[c] <= '0;
            end else begin
                if (cap_sig) sig_q[c] <= col_samples[c*SAMPLE_W +: SAMPLE_W];
                if (cap_ped) ped_q[c] <= col_samples[c*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    assign sig_word = sig_q[col_sel];
    assign ped_word = ped_q[col_sel];

    // R4
    sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_sig && !$past(rst)) |=> $stable(sig_q[0]));

endmodule

// File: rtl/cds_diff_stream.sv
module cds_diff_stream
    import cds_rowseq_pkg::*;
#(
    parameter int NUM_ROWS = 64,
    parameter int NUM_COLS = 128,
    parameter int SAMPLE_W = 16,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  phase_e                     phase,
    input  logic [ROW_W-1:0]           row_idx,
    input  logic [COL_W-1:0]           col_idx,
    input  logic [SAMPLE_W-1:0]        sig_word,
    input  logic [SAMPLE_W-1:0]        ped_word,
    output logic                       out_valid,
    output logic [ROW_W-1:0]           out_row,
    output logic [COL_W-1:0]           out_col,
    output logic signed [SAMPLE_W:0]   out_diff,
    output logic                       out_eof
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    assign out_valid = (phase == PH_STREAM);
    assign out_row   = row_idx;
    assign out_col   = col_idx;
    assign out_diff  = $signed({1'b0, sig_word}) - $signed({1'b0, ped_word});
    assign out_eof   = out_valid && (row_idx == LAST_ROW) && (col_idx == LAST_COL);

    // R6
    first_col_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(out_valid) && !$past(rst)) |-> (out_col == '0));

    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(rst)) |-> (out_col == $past(out_col) + 1'b1));

endmodule

// File: rtl/cds_row_sequencer.sv
module cds_row_sequencer
    import cds_rowseq_pkg::*;
#(
    parameter int NUM_ROWS   = 64,
    parameter int NUM_COLS   = 128,
    parameter int SAMPLE_W   = DEFAULT_SAMPLE_W,
    parameter int SETTLE_CYC = 2,
    parameter int CLEAR_CYC  = 2,
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic [NUM_COLS*SAMPLE_W-1:0] col_samples,
    output logic [NUM_ROWS-1:0]          gate_row,
    output logic [NUM_ROWS-1:0]          clear_row,
    output logic                         sig_strobe,
    output logic                         ped_strobe,
    output logic                         out_valid,
    output logic [ROW_W-1:0]             out_row,
    output logic [COL_W-1:0]             out_col,
    output logic signed [SAMPLE_W:0]     out_diff,
    output logic                         out_eof
);
    phase_e              phase;
    logic [ROW_W-1:0]    row_idx;
    logic [COL_W-1:0]    col_idx;
    logic [SAMPLE_W-1:0] sig_word, ped_word;

    cds_row_timer #(
        .NUM_ROWS  (NUM_ROWS),
        .NUM_COLS  (NUM_COLS),
        .SETTLE_CYC(SETTLE_CYC),
        .CLEAR_CYC (CLEAR_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .phase    (phase),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .gate_row (gate_row),
        .clear_row(clear_row),
        .sig_stb  (sig_strobe),
        .ped_stb  (ped_strobe)
    );

    cds_sample_bank #(
        .NUM_COLS(NUM_COLS),
        .SAMPLE_W(SAMPLE_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cap_sig    (sig_strobe),
        .cap_ped    (ped_strobe),
        .col_samples(col_samples),
        .col_sel    (col_idx),
        .sig_word   (sig_word),
        .ped_word   (ped_word)
    );

    cds_diff_stream #(
        .NUM_ROWS(NUM_ROWS),
        .NUM_COLS(NUM_COLS),
        .SAMPLE_W(SAMPLE_W)
    ) u_stream (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .sig_word (sig_word),
        .ped_word (ped_word),
        .out_valid(out_valid),
        .out_row  (out_row),
        .out_col  (out_col),
        .out_diff (out_diff),
        .out_eof  (out_eof)
    );

    // R8
    eof_ends_stream_chk: assert property (@(posedge clk) disable iff (rst)
        out_eof |=> (!out_valid || out_row == '0));

endmodule

// File: tb/sim_cds_row_sequencer.sv
`timescale 1ns/1ps
module sim_cds_row_sequencer;
    localparam int R  = 4;
    localparam int N  = 4;
    localparam int SW = 16;
    localparam int S  = 2;
    localparam int C  = 2;
    localparam int STREAM_PH = S + C + 2;
    localparam int PERIOD    = STREAM_PH + N;
    localparam int RW = $clog2(R);
    localparam int CW = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [N*SW-1:0] col_samples;
    logic [R-1:0] gate_row, clear_row;
    logic sig_strobe, ped_strobe, out_valid, out_eof;
    logic [RW-1:0] out_row;
    logic [CW-1:0] out_col;
    logic signed [SW:0] out_diff;

    always #5 clk = ~clk;

    cds_row_sequencer #(.NUM_ROWS(R), .NUM_COLS(N), .SAMPLE_W(SW),
                        .SETTLE_CYC(S), .CLEAR_CYC(C)) u0 (
        .clk(clk), .rst(rst), .run(run), .col_samples(col_samples),
        .gate_row(gate_row), .clear_row(clear_row),
        .sig_strobe(sig_strobe), .ped_strobe(ped_strobe),
        .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
        .out_diff(out_diff), .out_eof(out_eof));

    int n_cmp = 0;
    int n_bad = 0;
    int epoch = 0;
    bit done = 0;

    function automatic int f_sig(int r, int c, int e);
        int idx = r * N + c;
        if (idx == 0) return 65535;
        if (idx == 1) return 0;
        return (idx * 4099 + e * 977 + 13) % 65536;
    endfunction

    function automatic int f_ped(int r, int c, int e);
        int idx = r * N + c;
        if (idx == 0) return 0;
        if (idx == 1) return 65535;
        return (idx * 7919 + e * 3001 + 101) % 65536;
    endfunction

    // Bus model: real values only on strobe cycles, filler otherwise (R4)
    always_comb begin
        int rsel;
        rsel = 0;
        for (int i = 0; i < R; i++) if (gate_row[i]) rsel = i;
        col_samples = {N{16'hA5A5}};
        for (int c = 0; c < N; c++) begin
            if (sig_strobe) col_samples[c*SW +: SW] = SW'(f_sig(rsel, c, epoch));
            if (ped_strobe) col_samples[c*SW +: SW] = SW'(f_ped(rsel, c, epoch));
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Independent cycle model of the expected port behaviour
    bit m_act = 0;
    int m_row = 0;
    int m_ph  = 0;

    always @(negedge clk) begin
        if (rst) begin
            chk(gate_row == '0 && clear_row == '0, "R10 lines", gate_row, 0);
            chk(!sig_strobe && !ped_strobe && !out_valid, "R10 strobes", out_valid, 0);
            m_act = 0; m_row = 0; m_ph = 0;
        end else begin
            logic [R-1:0] eg, ec;
            bit es, ep, ev, ee;
            int ecol;
            eg = (m_act && m_ph < STREAM_PH) ? R'(1 << m_row) : '0;
            ec = (m_act && m_ph > S && m_ph <= S + C) ? R'(1 << m_row) : '0;
            es = m_act && m_ph == S;
            ep = m_act && m_ph == S + C + 1;
            ev = m_act && m_ph >= STREAM_PH;
            ecol = m_ph - STREAM_PH;
            ee = ev && m_row == R - 1 && ecol == N - 1;
            chk($countones(gate_row) <= 1, "R1 onehot", $countones(gate_row), 1);
            chk(gate_row == eg, m_act ? "R2/R7 gate" : "R9 gate idle", gate_row, eg);
            chk(clear_row == ec, "R3 clear", clear_row, ec);
            chk(sig_strobe == es && ped_strobe == ep, "R2 strobes",
                {sig_strobe, ped_strobe}, {es, ep});
            chk(out_valid == ev, "R6 valid", out_valid, ev);
            chk(out_eof == ee, "R8 eof", out_eof, ee);
            if (ev) begin
                longint ed;
                ed = f_sig(m_row, ecol, epoch) - f_ped(m_row, ecol, epoch);
                chk(out_row == m_row && out_col == ecol, "R6/R7 tag",
                    out_row * 100 + out_col, m_row * 100 + ecol);
                chk(out_diff == ed, "R5/R4 diff", out_diff, ed);
            end
            if (m_act) begin
                if (m_ph == PERIOD - 1) begin
                    m_ph = 0;
                    epoch++;
                    if (run) m_row = (m_row + 1) % R;
                    else begin m_act = 0; m_row = 0; end
                end else m_ph++;
            end else if (run) begin
                m_act = 1; m_ph = 0; m_row = 0;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(4);                 // R10: idle after reset
        run = 1'b1;                  // R7/R8: two full frames plus part of a third
        wait_cyc(2 * R * PERIOD + 13);
        run = 1'b0;                  // R9: stop mid-row
        wait_cyc(3 * PERIOD);
        run = 1'b1;                  // R9: single-cycle start runs exactly one row
        wait_cyc(1);
        run = 1'b0;
        wait_cyc(2 * PERIOD);
        run = 1'b1;                  // restart, then stop on a row boundary cycle
        wait_cyc(R * PERIOD + PERIOD);
        run = 1'b0;
        wait_cyc(2 * PERIOD);
        finish_run();
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule